// File: doc/BRIEF.md
# Erase Suspend/Resume Sequencer

This block is the sequencing core of a flash-style command handler for sector erase. It takes commands that have already been decoded from bus writes, each with a sector number. It keeps track of whether an erase is running, parked in the suspended state, or running again after a resume. It remembers which sector owns the erase and reports a mode code together with a busy flag and a toggling status bit.

A cycle counter stands in for the erase of the array. The erase advances only on cycles spent in the erasing state. While the erase is parked, the host may start a short program operation or enter the identification (autoselect) mode. A resume must name the parked sector. After a resume, a new suspend is not acted on until a parameterised number of cycles has passed. A suspend that arrives inside that window is held and carried out when the window closes.

Top module: `eraseSuspendCtl`

## Requirements
- R1: After reset the mode is 0 (read), busy is 0, toggle is 0 and suspSector is 0.
- R2: In read mode an erase command (cmdOp=1) moves the block to mode 1 (erasing), asserts busy and latches cmdSector onto suspSector. When the erase completes the block returns to mode 0 and suspSector clears to 0.
- R3: A suspend (cmdOp=2) in mode 1 with no hold-off pending moves the block to mode 2 (suspended) on that clock edge. suspSector keeps the erasing sector, busy drops, and erase progress stops.
- R4: In mode 2 a resume (cmdOp=3) whose cmdSector equals suspSector returns the block to mode 1. A resume naming any other sector is ignored, and the block stays in mode 2.
- R5: A resume received in mode 1 has no effect. The block stays erasing and suspSector is unchanged.
- R6: A suspend accepted at clock edge k is impossible before edge R+HOLD_CYCLES+1, where R is the edge of the last accepted resume. A suspend received earlier is held and takes effect exactly at edge R+HOLD_CYCLES+1. An erase command clears any hold-off.
- R7: In mode 2 a program command (cmdOp=4) enters mode 3 (program while suspended) for PROG_CYCLES cycles. During that time busy is 1 and toggle flips, as during an erase. The block then returns to mode 2.
- R8: In mode 2 an autoselect command (cmdOp=5) enters mode 4. Resume is ignored there. An exit command (cmdOp=6) returns the block to mode 2. Commands that do not apply to the current mode (such as suspend or autoselect in read mode) are ignored.
- R9: The toggle output inverts on every clock edge that finds busy set, and holds its value otherwise.
- R10: The erase completes after exactly ERASE_CYCLES clock edges spent in mode 1, however those edges are split by suspends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | A decoded command is present this cycle |
| cmdOp | input | 3 | Command code: 1 erase, 2 suspend, 3 resume, 4 program, 5 autoselect, 6 exit |
| cmdSector | input | SECTOR_W | Sector number carried with the command |
| mode | output | 3 | 0 read, 1 erasing, 2 suspended, 3 program while suspended, 4 autoselect while suspended |
| busy | output | 1 | Erase or suspended program in progress |
| toggle | output | 1 | Status bit that flips on every busy cycle |
| suspSector | output | SECTOR_W | Sector owning the current erase, 0 when idle |

## Verification
The deferred suspend is the hardest case to reach. It needs an erase that has already been suspended and resumed, and then a suspend whose arrival is placed at a chosen cycle inside the hold-off window. The bench runs an erase, suspends it, resumes it, and then issues a suspend at every offset from 1 to HOLD_CYCLES+1 after the resume. At each offset it checks that the block is still erasing one edge before the window closes and suspended right after. A second sweep moves the first suspend across every point of the erase and counts the cycles spent erasing. This shows that progress is frozen while parked.

// File: rtl/esc_pkg.sv
package esc_pkg;
  typedef enum logic [2:0] {
    MODE_READ  = 3'd0,
    MODE_ERASE = 3'd1,
    MODE_SUSP  = 3'd2,
    MODE_SPROG = 3'd3,
    MODE_SAUTO = 3'd4
  } mode_e;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_ERASE   = 3'd1,
    OP_SUSPEND = 3'd2,
    OP_RESUME  = 3'd3,
    OP_PROGRAM = 3'd4,
    OP_AUTOSEL = 3'd5,
    OP_EXIT    = 3'd6
  } op_e;

  typedef struct packed {
    logic eraseStart;
    logic eraseRun;
    logic loadHold;
    logic clearSector;
    logic progStart;
    logic progRun;
    logic busy;
  } strobe_t;
endpackage

// File: rtl/esc_ctrl.sv
module esc_ctrl
  import esc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cmdValid,
  input  logic [2:0] cmdOp,
  input  logic    eraseDone,
  input  logic    progDone,
  input  logic    holdBusy,
  input  logic    sectorMatch,
  output mode_e   modeQ,
  output strobe_t st
);
  mode_e modeD;
  logic  pendQ, pendD;
  op_e   opV;

  assign opV = cmdValid ? op_e'(cmdOp) : OP_NONE;

  always_comb begin
    modeD = modeQ;
    pendD = pendQ;
    st    = '0;
    case (modeQ)
      MODE_READ: begin
        if (opV == OP_ERASE) begin
          modeD         = MODE_ERASE;
          st.eraseStart = 1'b1;
        end
      end
      MODE_ERASE: begin
        st.eraseRun = 1'b1;
        st.busy     = 1'b1;
        if (eraseDone) begin
          modeD          = MODE_READ;
          st.clearSector = 1'b1;
          pendD          = 1'b0;
        end else if (opV == OP_SUSPEND || pendQ) begin
          if (holdBusy) begin
            pendD = 1'b1;
          end else begin
            modeD = MODE_SUSP;
            pendD = 1'b0;
          end
        end
      end
      MODE_SUSP: begin
        if (opV == OP_RESUME && sectorMatch) begin
          modeD       = MODE_ERASE;
          st.loadHold = 1'b1;
        end else if (opV == OP_PROGRAM) begin
          modeD        = MODE_SPROG;
          st.progStart = 1'b1;
        end else if (opV == OP_AUTOSEL) begin
          modeD = MODE_SAUTO;
        end
      end
      MODE_SPROG: begin
        st.progRun = 1'b1;
        st.busy    = 1'b1;
        if (progDone) modeD = MODE_SUSP;
      end
      MODE_SAUTO: begin
        if (opV == OP_EXIT) modeD = MODE_SUSP;
      end
      default: modeD = MODE_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= MODE_READ;
      pendQ <= 1'b0;
    end else begin
      modeQ <= modeD;
      pendQ <= pendD;
    end
  end

  // R4: a resume naming another sector leaves the block parked
  assert_mismatch_ignored_R4: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_SUSP && opV == OP_RESUME && !sectorMatch) |=> modeQ == MODE_SUSP);

  // R6: no suspend while the hold-off window is open
  assert_holdoff_R6: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_ERASE && holdBusy) |=> modeQ != MODE_SUSP);

  // R5: resume while erasing changes nothing
  assert_resume_noeffect_R5: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_ERASE && opV == OP_RESUME && !eraseDone && !pendQ) |=> modeQ == MODE_ERASE);

  // R7: a suspended program always returns to the parked state
  assert_prog_return_R7: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_SPROG && progDone) |=> modeQ == MODE_SUSP);
endmodule

// File: rtl/esc_dp.sv
module esc_dp
  import esc_pkg::*;
#(
  parameter int SECTOR_W     = 3,
  parameter int ERASE_CYCLES = 4000,
  parameter int HOLD_CYCLES  = 1000,
  parameter int PROG_CYCLES  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             st,
  input  logic [SECTOR_W-1:0] cmdSector,
  output logic                eraseDone,
  output logic                progDone,
  output logic                holdBusy,
  output logic                sectorMatch,
  output logic [SECTOR_W-1:0] sectorQ,
  output logic                toggleQ
);
  localparam int ERW = $clog2(ERASE_CYCLES);
  localparam int HW  = $clog2(HOLD_CYCLES + 1);
  localparam int PW  = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1;

  logic [ERW-1:0] eraseCnt;
  logic [HW-1:0]  holdCnt;
  logic [PW-1:0]  progCnt;

  assign eraseDone   = eraseCnt == ERW'(ERASE_CYCLES - 1);
  assign progDone    = progCnt == PW'(PROG_CYCLES - 1);
  assign holdBusy    = holdCnt != '0;
  assign sectorMatch = cmdSector == sectorQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eraseCnt <= '0;
      holdCnt  <= '0;
      progCnt  <= '0;
      sectorQ  <= '0;
      toggleQ  <= 1'b0;
    end else begin
      if (st.eraseStart) begin
        sectorQ <= cmdSector;
      end else if (st.clearSector) begin
        sectorQ <= '0;
      end

      if (st.eraseStart || st.clearSector) begin
        eraseCnt <= '0;
      end else if (st.eraseRun && !eraseDone) begin
        eraseCnt <= eraseCnt + 1'b1;
      end

      if (st.eraseStart) begin
        holdCnt <= '0;
      end else if (st.loadHold) begin
        holdCnt <= HW'(HOLD_CYCLES);
      end else if (holdBusy) begin
        holdCnt <= holdCnt - 1'b1;
      end

      if (st.progStart) begin
        progCnt <= '0;
      end else if (st.progRun && !progDone) begin
        progCnt <= progCnt + 1'b1;
      end

      if (st.busy) toggleQ <= ~toggleQ;
    end
  end

  // R3: erase progress is frozen whenever the control is not running it
  assert_erase_frozen_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!st.eraseRun && !st.eraseStart && !st.clearSector) |=> $stable(eraseCnt));

  // R6: the hold-off window counts down one step per cycle
  assert_hold_countdown_R6: assert property (@(posedge clk) disable iff (!rstN)
    (holdBusy && !st.loadHold && !st.eraseStart) |=> holdCnt == $past(holdCnt) - 1'b1);

  // R2: the owning sector is held steady while an erase is outstanding
  assert_sector_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!st.eraseStart && !st.clearSector) |=> $stable(sectorQ));
endmodule

// File: rtl/eraseSuspendCtl.sv
module eraseSuspendCtl
  import esc_pkg::*;
#(
  parameter int SECTOR_W     = 3,
  parameter int ERASE_CYCLES = 4000,
  parameter int HOLD_CYCLES  = 1000,
  parameter int PROG_CYCLES  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdValid,
  input  logic [2:0]          cmdOp,
  input  logic [SECTOR_W-1:0] cmdSector,
  output logic [2:0]          mode,
  output logic                busy,
  output logic                toggle,
  output logic [SECTOR_W-1:0] suspSector
);
  strobe_t st;
  mode_e   modeQ;
  logic    eraseDone, progDone, holdBusy, sectorMatch;

  esc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .eraseDone(eraseDone), .progDone(progDone), .holdBusy(holdBusy),
    .sectorMatch(sectorMatch), .modeQ(modeQ), .st(st)
  );

  esc_dp #(
    .SECTOR_W(SECTOR_W), .ERASE_CYCLES(ERASE_CYCLES),
    .HOLD_CYCLES(HOLD_CYCLES), .PROG_CYCLES(PROG_CYCLES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .cmdSector(cmdSector),
    .eraseDone(eraseDone), .progDone(progDone), .holdBusy(holdBusy),
    .sectorMatch(sectorMatch), .sectorQ(suspSector), .toggleQ(toggle)
  );

  assign mode = modeQ;
  assign busy = st.busy;

  // R9: status bit flips on every busy cycle
  assert_toggle_R9: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> toggle != $past(toggle));

  assert_toggle_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> $stable(toggle));
endmodule

// File: tb/eraseSuspendCtl_bench.sv
`timescale 1ns/1ps
module eraseSuspendCtl_bench;
  localparam int SW = 3;
  localparam int NE = 20;
  localparam int NH = 6;
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [2:0] cmdOp = 3'd0;
  logic [SW-1:0] cmdSector = '0;
  logic [2:0] mode;
  logic busy, toggle;
  logic [SW-1:0] suspSector;

  int total = 0;
  int bad = 0;
  int erCount = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  eraseSuspendCtl #(.SECTOR_W(SW), .ERASE_CYCLES(NE), .HOLD_CYCLES(NH), .PROG_CYCLES(NP))
    u_eraseSuspendCtl (.clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
      .cmdSector(cmdSector), .mode(mode), .busy(busy), .toggle(toggle), .suspSector(suspSector));

  always @(negedge clk) if (rstN && mode == 3'd1) erCount++;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cmd(input int op, input int sec);
    cmdValid = 1'b1; cmdOp = 3'(op); cmdSector = SW'(sec);
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 3'd0; cmdSector = '0;
  endtask

  task automatic waitRead();
    int guard = 0;
    while (mode != 3'd0 && guard < 500) begin
      @(negedge clk);
      guard++;
    end
  endtask

  initial begin
    int tg;
    idle(3);
    // R1 reset state
    chk("R1 mode", mode, 0);
    chk("R1 busy", busy, 0);
    chk("R1 toggle", toggle, 0);
    chk("R1 sector", suspSector, 0);
    rstN = 1'b1;
    idle(1);
    // R8 commands not valid in read mode are ignored
    cmd(2, 0); chk("R8 suspend in read", mode, 0);
    cmd(5, 0); chk("R8 autosel in read", mode, 0);

    // R2 / R10 plain erase for each sector
    for (int s = 0; s < 8; s++) begin
      erCount = 0;
      cmd(1, s);
      chk("R2 erasing", mode, 1);
      chk("R2 busy", busy, 1);
      chk("R2 sector", suspSector, s);
      waitRead();
      chk("R10 plain length", erCount, NE);
      chk("R2 sector cleared", suspSector, 0);
    end

    // R3 / R4 / R5 / R10 suspend at every point of the erase
    for (int a = 0; a <= NE - 3; a++) begin
      int s = a % 8;
      erCount = 0;
      cmd(1, s);
      idle(a);
      cmd(2, 0);
      chk("R3 suspended", mode, 2);
      chk("R3 busy low", busy, 0);
      chk("R3 sector kept", suspSector, s);
      tg = toggle;
      idle(3);
      chk("R9 toggle still", toggle, tg);
      chk("R3 still parked", mode, 2);
      cmd(3, (s + 1) % 8);
      chk("R4 mismatch ignored", mode, 2);
      cmd(3, s);
      chk("R4 resumed", mode, 1);
      cmd(3, s);
      chk("R5 repeat resume", mode, 1);
      chk("R5 sector", suspSector, s);
      waitRead();
      chk("R10 split length", erCount, NE);
      chk("R2 sector cleared", suspSector, 0);
    end

    // R6 suspend at every offset after a resume
    for (int j = 1; j <= NH + 1; j++) begin
      int s = j % 8;
      cmd(1, s);
      cmd(2, 0);
      cmd(3, s);
      idle(j - 1);
      cmd(2, 0);
      if (j <= NH) begin
        idle(NH - j);
        chk("R6 deferred", mode, 1);
        idle(1);
      end
      chk("R6 taken at window end", mode, 2);
      cmd(3, s);
      waitRead();
    end

    // R7 / R8 / R9 program and autoselect while parked
    cmd(1, 5);
    cmd(2, 0);
    cmd(7, 0);
    chk("R8 unknown op ignored", mode, 2);
    cmd(4, 0);
    chk("R7 program mode", mode, 3);
    chk("R7 busy", busy, 1);
    tg = toggle;
    for (int k = 1; k < NP; k++) begin
      idle(1);
      chk("R7 still programming", mode, 3);
      chk("R9 toggle flips", toggle, 1 - tg);
      tg = toggle;
    end
    idle(1);
    chk("R7 back to parked", mode, 2);
    chk("R7 busy low", busy, 0);
    cmd(5, 0);
    chk("R8 autoselect", mode, 4);
    cmd(3, 5);
    chk("R8 resume ignored", mode, 4);
    cmd(6, 0);
    chk("R8 exit", mode, 2);
    cmd(3, 5);
    chk("R4 resume after program", mode, 1);
    cmd(5, 0);
    chk("R8 autosel while erasing", mode, 1);
    waitRead();
    chk("R2 done", mode, 0);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule